// File: doc/BRIEF.md
# External Interrupt Trigger and Pending Controller

This block watches 24 asynchronous interrupt pins. It turns each one into a latched request, according to a trigger condition that software selects per pin. Every pin is first brought into the clock domain through a short flop chain. The pin's 4-bit trigger code then decides whether the block responds to a level (high or low) or to an edge (rising, falling or both). When the condition is met, the pin's bit in a pending register is set. A mask register decides which pending bits may reach the outputs.

Six request lines leave the block toward a main interrupt controller. Lines 0 to 3 each belong to one of pins 0 to 3. Line 4 is the OR of the unmasked pending bits of pins 4 to 7. Line 5 is the OR of the unmasked pending bits of pins 8 to 23. A build parameter can take pins 0 to 3 out of the local pending and mask logic. In that case a registered copy of their detector result drives lines 0 to 3, and acknowledge and masking happen upstream.

Software reaches the block through a plain synchronous register port: byte address, write strobe, 32-bit write data and combinational read data.

Top module: `extint_ctrl`

## Requirements
- R1: After reset every mask bit is 1, every pending bit is 0, every trigger field reads 0, and all six request lines are low.
- R2: The trigger field of pin i is bits 4*(i%8)+3 down to 4*(i%8) of the configuration word at byte address 0x88 + 4*(i/8). The three words read back exactly what was written.
- R3: Trigger code 0 (low level) and code 1 (high level) set the pending bit on every clock while the synchronized pin is at the active level. A clear issued while the level persists therefore leaves the bit set.
- R4: Code 4 latches a rising edge, code 2 a falling edge and code 6 either edge. A pin change appears in the pending register three clocks after it is applied. Each edge sets the bit once, and the opposite edge of a single-edge code is ignored.
- R5: Codes 3, 5 and 7 through 15 never set a pending bit, whatever the pin does.
- R6: The pending register at 0xa8 is write-one-to-clear. Writing 0 to a bit leaves it unchanged, and bits 31 to 24 read as 0.
- R7: The mask register at 0xa4 is written whole. A 1 in bit i blocks pin i from the request lines, while its pending bit still latches. Bits 31 to 24 read as 0.
- R8: Line 4 is high exactly when some pin in 4..7 is both pending and unmasked. Line 5 is high exactly when some pin in 8..23 is both pending and unmasked.
- R9: Without bypass, line k (k = 0..3) is high exactly when pending bit k is set and mask bit k is clear.
- R10: With bypass, pending bits 0..3 always read 0 and mask bits 0..3 have no effect. Line k goes high three clocks after the triggering pin change. For an edge it stays high for one clock; for a level it stays high while the level lasts.
- R11: When a clear of a pending bit and a new event for that bit land on the same clock, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_i | input | 24 | Asynchronous external interrupt pins |
| reg_addr | input | 8 | Register byte address |
| reg_wr | input | 1 | Write strobe, one clock per write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| irq_o | output | 6 | Request lines: 0..3 direct, 4 for pins 4..7, 5 for pins 8..23 |

## Verification
The trigger logic is tried with:
- single rising and falling pin transitions under each edge code, which separates rising from falling from both-edge handling;
- pins held at a level across a clear, which separates level behaviour from edge behaviour;
- every undefined code with the pin toggling, to show that those codes stay silent.

Single pins inside each output group are unmasked one at a time, which shows which line each pin reaches and that the mask holds requests back. A second instance built with bypass compares the one-clock pulse of an edge against the held level on the direct lines. A clear written in the very cycle an edge arrives shows that the new event survives the clear.

// File: rtl/extint_pkg.sv
// Package: shared constants of the external interrupt controller.
// Holds the trigger code values and the register byte offsets used by the
// register file and the detectors. Assumes byte addressing, 32-bit words.
package extint_pkg;

    // Trigger codes, one 4-bit field per pin
    localparam logic [3:0] TRIG_LOW  = 4'd0;
    localparam logic [3:0] TRIG_HIGH = 4'd1;
    localparam logic [3:0] TRIG_FALL = 4'd2;
    localparam logic [3:0] TRIG_RISE = 4'd4;
    localparam logic [3:0] TRIG_BOTH = 4'd6;

    localparam int TRIG_W          = 4;
    localparam int WORD_W          = 32;
    localparam int FIELDS_PER_WORD = WORD_W / TRIG_W;

    // Register byte offsets
    localparam int OFS_CFG  = 'h88;
    localparam int OFS_MASK = 'hA4;
    localparam int OFS_PEND = 'hA8;

    // True for the five trigger codes that have a meaning
    function automatic logic trig_defined(input logic [3:0] code);
        return (code == TRIG_LOW) || (code == TRIG_HIGH) || (code == TRIG_FALL) ||
               (code == TRIG_RISE) || (code == TRIG_BOTH);
    endfunction

endpackage

// File: rtl/extint_sync.sv
// Module: extint_sync
// Brings a vector of asynchronous pins into the clock domain through a
// chain of STAGES flops, and keeps one extra flop of history for edge
// detection. Assumes each pin is a slow, independent asynchronous level.
module extint_sync #(
    parameter int W      = 24,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o,
    output logic [W-1:0] prev_o
);
    logic [W-1:0] stage_q [STAGES];
    logic [W-1:0] prev_q;

    // Purpose: shift pins through the synchronizer chain and keep history
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
            prev_q <= '0;
        end else begin
            stage_q[0] <= async_i;
            for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
            prev_q <= stage_q[STAGES-1];
        end
    end

    assign sync_o = stage_q[STAGES-1];
    assign prev_o = prev_q;

endmodule

// File: rtl/extint_detect.sv
// Module: extint_detect
// Trigger decoder for one pin. Compares the current synchronized sample
// with the previous one, or looks at the level alone, as the 4-bit code
// selects. Assumes cur_i and prev_i are consecutive samples of one flop chain.
module extint_detect
    import extint_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cur_i,
    input  logic       prev_i,
    input  logic [3:0] code_i,
    output logic       hit_o
);
    // Purpose: decode the trigger code into a per-cycle event
    always_comb begin
        case (code_i)
            TRIG_LOW:  hit_o = ~cur_i;
            TRIG_HIGH: hit_o = cur_i;
            TRIG_FALL: hit_o = prev_i & ~cur_i;
            TRIG_RISE: hit_o = cur_i & ~prev_i;
            TRIG_BOTH: hit_o = cur_i ^ prev_i;
            default:   hit_o = 1'b0;
        endcase
    end

    // R5: an undefined code gives no event
    a_r5_undef_silent: assert property (@(posedge clk) disable iff (!rst_n)
        !trig_defined(code_i) |-> !hit_o);

    // R4: a single-edge code fires for at most one cycle per edge
    a_r4_rise_once: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_o && code_i == TRIG_RISE) |=> (!hit_o || code_i != TRIG_RISE));
    a_r4_fall_once: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_o && code_i == TRIG_FALL) |=> (!hit_o || code_i != TRIG_FALL));

endmodule

// File: rtl/extint_regs.sv
// Module: extint_regs
// Register file: trigger configuration words, the mask register and the
// write-one-to-clear pending register. Pending bits of bypassed pins are
// held at zero. Assumes one-cycle write strobes and combinational reads.
module extint_regs
    import extint_pkg::*;
#(
    parameter int NUM_IN        = 24,
    parameter int NUM_DIRECT    = 4,
    parameter bit BYPASS_DIRECT = 1'b0,
    parameter int ADDR_W        = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [ADDR_W-1:0]        reg_addr,
    input  logic                     reg_wr,
    input  logic [WORD_W-1:0]        reg_wdata,
    output logic [WORD_W-1:0]        reg_rdata,
    input  logic [NUM_IN-1:0]        hit_i,
    output logic [TRIG_W*NUM_IN-1:0] cfg_o,
    output logic [NUM_IN-1:0]        mask_o,
    output logic [NUM_IN-1:0]        pend_o
);
    localparam int NUM_CFG_WORDS = (NUM_IN + FIELDS_PER_WORD - 1) / FIELDS_PER_WORD;
    localparam logic [NUM_IN-1:0] KEEP =
        BYPASS_DIRECT ? ({NUM_IN{1'b1}} << NUM_DIRECT) : {NUM_IN{1'b1}};

    logic [WORD_W-1:0] cfg_q [NUM_CFG_WORDS];
    logic [NUM_IN-1:0] mask_q;
    logic [NUM_IN-1:0] pend_q;
    logic              sel_mask;
    logic              sel_pend;
    logic [NUM_IN-1:0] clr_bits;

    assign sel_mask = (reg_addr == ADDR_W'(OFS_MASK));
    assign sel_pend = (reg_addr == ADDR_W'(OFS_PEND));
    assign clr_bits = (reg_wr && sel_pend) ? reg_wdata[NUM_IN-1:0] : '0;

    // Purpose: hold the trigger configuration words
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int j = 0; j < NUM_CFG_WORDS; j++) cfg_q[j] <= '0;
        end else if (reg_wr) begin
            for (int j = 0; j < NUM_CFG_WORDS; j++)
                if (reg_addr == ADDR_W'(OFS_CFG + 4*j)) cfg_q[j] <= reg_wdata;
        end
    end

    // Purpose: hold the mask register, fully masked out of reset
    always_ff @(posedge clk) begin
        if (!rst_n)                mask_q <= '1;
        else if (reg_wr && sel_mask) mask_q <= reg_wdata[NUM_IN-1:0];
    end

    // Purpose: latch events and apply write-one-to-clear; a new event wins
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= ((pend_q & ~clr_bits) | hit_i) & KEEP;
    end

    // Purpose: combinational read mux, unused upper bits read as zero
    always_comb begin
        reg_rdata = '0;
        if (sel_mask) reg_rdata = WORD_W'(mask_q);
        if (sel_pend) reg_rdata = WORD_W'(pend_q);
        for (int j = 0; j < NUM_CFG_WORDS; j++)
            if (reg_addr == ADDR_W'(OFS_CFG + 4*j)) reg_rdata = cfg_q[j];
    end

    // Flatten the configuration words into one field per pin
    for (genvar i = 0; i < NUM_IN; i++) begin : g_field
        assign cfg_o[TRIG_W*i +: TRIG_W] =
            cfg_q[i / FIELDS_PER_WORD][TRIG_W*(i % FIELDS_PER_WORD) +: TRIG_W];
    end

    assign mask_o = mask_q;
    assign pend_o = pend_q;

    // R6: a written one clears its bit unless an event arrives that cycle
    a_r6_w1c: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && sel_pend) |=>
        ((pend_q & $past(reg_wdata[NUM_IN-1:0] & ~hit_i)) == '0));

    // R11: every event on a local pin is present in the next cycle
    a_r11_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (|(hit_i & KEEP)) |=>
        ((pend_q & $past(hit_i & KEEP)) == $past(hit_i & KEEP)));

endmodule

// File: rtl/extint_ctrl.sv
// Module: extint_ctrl (top)
// External interrupt controller: synchronizes 24 pins, decodes a trigger
// code per pin, latches events into a maskable pending register and folds
// them into six request lines (four direct, two shared groups). With
// BYPASS_DIRECT set, the direct pins skip local pending and mask and drive
// their lines from a registered copy of the detector output.
// Assumes NUM_DIRECT < GROUP_A_HI < NUM_IN - 1 and NUM_IN < 32.
module extint_ctrl
    import extint_pkg::*;
#(
    parameter int NUM_IN        = 24,
    parameter int NUM_DIRECT    = 4,
    parameter int GROUP_A_HI    = 7,
    parameter int SYNC_STAGES   = 2,
    parameter bit BYPASS_DIRECT = 1'b0,
    parameter int ADDR_W        = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_IN-1:0]     pin_i,
    input  logic [ADDR_W-1:0]     reg_addr,
    input  logic                  reg_wr,
    input  logic [31:0]           reg_wdata,
    output logic [31:0]           reg_rdata,
    output logic [NUM_DIRECT+1:0] irq_o
);
    localparam int LINE_A = NUM_DIRECT;
    localparam int LINE_B = NUM_DIRECT + 1;

    logic [NUM_IN-1:0]        sync_w;
    logic [NUM_IN-1:0]        prev_w;
    logic [NUM_IN-1:0]        hit_w;
    logic [TRIG_W*NUM_IN-1:0] cfg_w;
    logic [NUM_IN-1:0]        mask_w;
    logic [NUM_IN-1:0]        pend_w;
    logic [NUM_IN-1:0]        live_w;

    extint_sync #(.W(NUM_IN), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pin_i),
        .sync_o  (sync_w),
        .prev_o  (prev_w)
    );

    for (genvar i = 0; i < NUM_IN; i++) begin : g_det
        extint_detect u_det (
            .clk    (clk),
            .rst_n  (rst_n),
            .cur_i  (sync_w[i]),
            .prev_i (prev_w[i]),
            .code_i (cfg_w[TRIG_W*i +: TRIG_W]),
            .hit_o  (hit_w[i])
        );
    end

    extint_regs #(
        .NUM_IN        (NUM_IN),
        .NUM_DIRECT    (NUM_DIRECT),
        .BYPASS_DIRECT (BYPASS_DIRECT),
        .ADDR_W        (ADDR_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .hit_i     (hit_w),
        .cfg_o     (cfg_w),
        .mask_o    (mask_w),
        .pend_o    (pend_w)
    );

    assign live_w = pend_w & ~mask_w;

    // Shared group lines
    assign irq_o[LINE_A] = |live_w[GROUP_A_HI:NUM_DIRECT];
    assign irq_o[LINE_B] = |live_w[NUM_IN-1:GROUP_A_HI+1];

    if (BYPASS_DIRECT) begin : g_bypass
        logic [NUM_DIRECT-1:0] direct_q;

        // Purpose: register detector events of the direct pins for upstream
        always_ff @(posedge clk) begin
            if (!rst_n) direct_q <= '0;
            else        direct_q <= hit_w[NUM_DIRECT-1:0];
        end

        assign irq_o[NUM_DIRECT-1:0] = direct_q;

        // R10: bypassed pins leave no local pending state
        a_r10_no_local: assert property (@(posedge clk) disable iff (!rst_n)
            live_w[NUM_DIRECT-1:0] == '0);
    end else begin : g_local
        assign irq_o[NUM_DIRECT-1:0] = live_w[NUM_DIRECT-1:0];
    end

    // R7: a fully masked register keeps both group lines low
    a_r7_mask_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_w == '1) |-> (irq_o[LINE_B:LINE_A] == 2'b00));

endmodule

// File: tb/test_extint_ctrl.sv
module test_extint_ctrl;
    localparam int CLK_P = 10;
    localparam logic [7:0] A_CFG0 = 8'h88;
    localparam logic [7:0] A_CFG1 = 8'h8C;
    localparam logic [7:0] A_CFG2 = 8'h90;
    localparam logic [7:0] A_MASK = 8'hA4;
    localparam logic [7:0] A_PEND = 8'hA8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] pins = '0;
    logic [7:0]  addr = '0;
    logic        wr = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata, rdata_b;
    logic [5:0]  irq, irq_b;
    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    extint_ctrl i_extint_ctrl (
        .clk(clk), .rst_n(rst_n), .pin_i(pins), .reg_addr(addr), .reg_wr(wr),
        .reg_wdata(wdata), .reg_rdata(rdata), .irq_o(irq)
    );

    extint_ctrl #(.BYPASS_DIRECT(1'b1)) i_extint_ctrl_byp (
        .clk(clk), .rst_n(rst_n), .pin_i(pins), .reg_addr(addr), .reg_wr(wr),
        .reg_wdata(wdata), .reg_rdata(rdata_b), .irq_o(irq_b)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
        addr = a; wdata = d; wr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] m, output logic [31:0] b);
        addr = a;
        #1;
        m = rdata;
        b = rdata_b;
    endtask

    task automatic clear_all();
        wr_reg(A_PEND, 32'h00FF_FFFF);
    endtask

    task automatic t_reset();
        logic [31:0] m, b;
        rst_n = 1'b0;
        cyc(2);
        rd(A_MASK, m, b);  check("R1 mask", m, 32'h00FF_FFFF);
        check("R1 mask bypass", b, 32'h00FF_FFFF);
        rd(A_PEND, m, b);  check("R1 pend", m, 32'h0);
        rd(A_CFG0, m, b);  check("R1 cfg0", m, 32'h0);
        rd(A_CFG2, m, b);  check("R1 cfg2", m, 32'h0);
        check("R1 irq", {26'd0, irq}, 32'h0);
        rst_n = 1'b1;
        cyc(1);
    endtask

    task automatic t_cfg_layout();
        logic [31:0] m, b;
        wr_reg(A_CFG0, 32'h7654_3210);
        wr_reg(A_CFG1, 32'hA5C3_1E96);
        wr_reg(A_CFG2, 32'h0F1E_2D3C);
        rd(A_CFG0, m, b); check("R2 cfg0", m, 32'h7654_3210);
        rd(A_CFG1, m, b); check("R2 cfg1", m, 32'hA5C3_1E96);
        rd(A_CFG2, m, b); check("R2 cfg2", m, 32'h0F1E_2D3C);
        wr_reg(A_CFG0, 32'h4444_4444);
        wr_reg(A_CFG1, 32'h4444_6244);
        wr_reg(A_CFG2, 32'h4444_4444);
        cyc(3);
        clear_all();
        rd(A_PEND, m, b); check("R6 pend cleared", m, 32'h0);
    endtask

    task automatic t_edges();
        logic [31:0] m, b;
        pins[9] = 1'b1; cyc(3);
        rd(A_PEND, m, b); check("R4 rise pin9", m, 32'h200);
        check("R7 masked irq", {26'd0, irq}, 32'h0);
        wr_reg(A_PEND, 32'h0);
        rd(A_PEND, m, b); check("R6 write zero keeps", m, 32'h200);
        cyc(3);
        wr_reg(A_PEND, 32'h200);
        rd(A_PEND, m, b); check("R6 w1c / R4 once", m, 32'h0);
        pins[9] = 1'b0; cyc(3);
        rd(A_PEND, m, b); check("R4 rise ignores fall", m, 32'h0);
        pins[10] = 1'b1; cyc(3);
        rd(A_PEND, m, b); check("R4 fall ignores rise", m, 32'h0);
        pins[10] = 1'b0; cyc(3);
        rd(A_PEND, m, b); check("R4 fall pin10", m, 32'h400);
        clear_all();
        pins[11] = 1'b1; cyc(3);
        rd(A_PEND, m, b); check("R4 both rise pin11", m, 32'h800);
        clear_all();
        pins[11] = 1'b0; cyc(3);
        rd(A_PEND, m, b); check("R4 both fall pin11", m, 32'h800);
        clear_all();
    endtask

    task automatic t_levels();
        logic [31:0] m, b;
        wr_reg(A_CFG1, 32'h4441_6244);
        pins[12] = 1'b1; cyc(3);
        rd(A_PEND, m, b); check("R3 high level", m, 32'h1000);
        clear_all();
        rd(A_PEND, m, b); check("R3 high persists over clear", m, 32'h1000);
        pins[12] = 1'b0; cyc(3);
        clear_all();
        rd(A_PEND, m, b); check("R3 high level gone", m, 32'h0);
        wr_reg(A_CFG1, 32'h4401_6244);
        cyc(2);
        rd(A_PEND, m, b); check("R3 low level", m, 32'h2000);
        clear_all();
        rd(A_PEND, m, b); check("R3 low persists over clear", m, 32'h2000);
        pins[13] = 1'b1; cyc(3);
        clear_all();
        rd(A_PEND, m, b); check("R3 low level gone", m, 32'h0);
    endtask

    task automatic t_undef();
        logic [31:0] m, b;
        logic [3:0] codes [5] = '{4'd3, 4'd5, 4'd7, 4'd9, 4'd15};
        for (int k = 0; k < 5; k++) begin
            wr_reg(A_CFG1, 32'h4001_6244 | (32'(codes[k]) << 24));
            pins[14] = 1'b1; cyc(3);
            rd(A_PEND, m, b); check("R5 undefined code high", m, 32'h0);
            pins[14] = 1'b0; cyc(3);
            rd(A_PEND, m, b); check("R5 undefined code low", m, 32'h0);
        end
        wr_reg(A_CFG1, 32'h4444_4444);
        cyc(1);
        clear_all();
    endtask

    task automatic t_mask_group();
        logic [31:0] m, b;
        pins[5] = 1'b1; cyc(3);
        rd(A_PEND, m, b); check("R7 latch while masked", m, 32'h20);
        check("R7 masked quiet", {26'd0, irq}, 32'h0);
        wr_reg(A_MASK, 32'hFFFF_FFDF);
        rd(A_MASK, m, b); check("R7 mask readback", m, 32'h00FF_FFDF);
        check("R8 line4 group", {26'd0, irq}, 32'h10);
        wr_reg(A_PEND, 32'h20);
        check("R8 line4 cleared", {26'd0, irq}, 32'h0);
        wr_reg(A_MASK, 32'h00FF_FFFF);
        pins[20] = 1'b1; cyc(3);
        wr_reg(A_MASK, 32'h00EF_FFFF);
        check("R8 line5 group", {26'd0, irq}, 32'h20);
        wr_reg(A_MASK, 32'h00FF_FFFF);
        check("R7 remask quiet", {26'd0, irq}, 32'h0);
        rd(A_PEND, m, b); check("R7 pending kept", m, 32'h10_0000);
        clear_all();
    endtask

    task automatic t_direct();
        logic [31:0] m, b;
        pins[2] = 1'b1; cyc(3);
        check("R10 bypass edge pulse", {26'd0, irq_b}, 32'h4);
        check("R9 masked direct quiet", {26'd0, irq}, 32'h0);
        cyc(1);
        check("R10 bypass pulse one clock", {26'd0, irq_b}, 32'h0);
        rd(A_PEND, m, b);
        check("R9 local pending", m, 32'h4);
        check("R10 bypass no pending", b, 32'h0);
        wr_reg(A_MASK, 32'h00FF_FFFB);
        check("R9 direct line2", {26'd0, irq}, 32'h4);
        wr_reg(A_PEND, 32'h4);
        check("R9 direct cleared", {26'd0, irq}, 32'h0);
        wr_reg(A_MASK, 32'h00FF_FFFF);
        wr_reg(A_CFG0, 32'h4444_1444);
        pins[3] = 1'b1; cyc(3);
        check("R10 bypass level on", {26'd0, irq_b}, 32'h8);
        cyc(2);
        check("R10 bypass level held", {26'd0, irq_b}, 32'h8);
        pins[3] = 1'b0; cyc(3);
        check("R10 bypass level off", {26'd0, irq_b}, 32'h0);
        clear_all();
    endtask

    task automatic t_collide();
        logic [31:0] m, b;
        pins[16] = 1'b1;
        @(posedge clk); @(negedge clk);
        @(posedge clk); @(negedge clk);
        wr_reg(A_PEND, 32'h1_0000);
        rd(A_PEND, m, b); check("R11 event beats clear", m, 32'h1_0000);
        wr_reg(A_PEND, 32'h1_0000);
        rd(A_PEND, m, b); check("R11 later clear works", m, 32'h0);
    endtask

    initial begin
        t_reset();
        t_cfg_layout();
        t_edges();
        t_levels();
        t_undef();
        t_mask_group();
        t_direct();
        t_collide();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule